// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a control transfer on endpoint zero from its SETUP packet through the data stage to the status stage. For each direction it picks the handshake that the packet engine must give next: accept (VALID), hold off (NAK) or refuse (STALL). It also gives the data toggle the engine must expect or send, and a one-cycle pulse when a transfer completes.

The packet engine reports decoded events to the block as single-cycle pulses. These are SETUP, IN and OUT tokens, the 8-byte SETUP payload, a received ACK for data the device sent, and an accepted OUT data packet together with its toggle. The application side supplies the number of bytes it will return for a read, and a success or failure pulse for the requested operation.

On the last IN data packet of a control read, the block arms the OUT direction VALID at the same time as the IN direction. If the final ACK is lost, a status OUT token that arrives anyway closes the data stage and the transfer finishes.

Top module: `ctl_ep_sequencer`

## Requirements
- R1: A SETUP token pulse in any state moves the stage to SETUP_DECODE (code 1) on the next cycle. Both responses are then NAK. Response codes are NAK=0, VALID=1, STALL=2.
- R2: The decode uses bit 7 of payload byte 0 (set means device-to-host) and the 16-bit request length in bytes 6 (low) and 7 (high). Byte k sits at bits 8k+7..8k. A zero length goes to STATUS_IN (5). A read goes to DATA_IN (2), or to LAST_IN_WAIT (4) when it has one packet. A write goes to DATA_OUT (3).
- R3: While an IN data packet that is not the last is pending, IN answers VALID and OUT answers STALL. An OUT token at that point moves the stage to STALLED (7).
- R4: While the last IN packet is pending (stage 4), both directions answer VALID. Its ACK moves the stage to STATUS_OUT (6).
- R5: An OUT token in stage 4 closes the data stage as if the ACK had arrived (stage 6). The next accepted OUT packet completes the transfer.
- R6: An IN token without an ACK leaves the stage, the packet count and the toggle unchanged, so the same packet is sent again.
- R7: In a write, an OUT data packet advances only when its toggle matches the expected one. Otherwise it changes nothing. IN answers STALL before the last OUT packet and NAK while the last is pending. A repeated last packet in STATUS_IN changes nothing.
- R8: In STATUS_IN, IN answers NAK until application success, then VALID, and the ACK completes the transfer. An application failure moves any active stage to STALLED.
- R9: The toggle output is DATA1 (1) for the first data packet after decode and alternates per accepted packet. It is always DATA1 in the status stages.
- R10: Each completed transfer raises the one-cycle done pulse exactly once, including when the lost-ACK path is taken.
- R11: In STALLED both directions answer STALL until a SETUP token arrives.
- R12: The packet count is ceil(L / MPS). For a read, L is the smaller of the application length and the request length; for a write it is the request length. A read adds one zero-length packet when L is a multiple of MPS and below the request length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_setup | input | 1 | SETUP token seen |
| tok_in | input | 1 | IN token seen |
| tok_out | input | 1 | OUT token seen |
| setup_vld | input | 1 | SETUP payload received |
| setup_pkt | input | 64 | SETUP payload, byte k at bits 8k+7..8k |
| rd_len | input | 16 | Bytes the application returns for a read |
| hs_ack | input | 1 | ACK received for device-sent data |
| odat_ok | input | 1 | OUT data packet received intact |
| odat_data1 | input | 1 | Toggle of that OUT packet (1 = DATA1) |
| app_ok | input | 1 | Application reports success |
| app_err | input | 1 | Application reports failure |
| in_resp | output | 2 | Response for IN tokens |
| out_resp | output | 2 | Response for OUT tokens |
| pid_data1 | output | 1 | Expected or sent data toggle |
| stage | output | 3 | Current stage code |
| xfer_done | output | 1 | Transfer complete pulse |

## Verification
Two things can land on the same packet. One is the close of the data stage. The other is the start of the status stage, when the OUT token of a control read arrives while the last IN is still waiting for its ACK. Random reads drop that ACK about half the time and send the status OUT straight away. The bench then checks that the stage moves to STATUS_OUT, that the following packet completes the transfer, and that the count of done pulses equals the number of finished transfers. For writes, stale-toggle retries are mixed in, both during the data stage and after it has closed, and the bench confirms that they change nothing.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [1:0] {
    RSP_NAK   = 2'd0,
    RSP_VALID = 2'd1,
    RSP_STALL = 2'd2
  } rsp_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DECODE   = 3'd1,
    ST_DATA_IN  = 3'd2,
    ST_DATA_OUT = 3'd3,
    ST_LAST_IN  = 3'd4,
    ST_STAT_IN  = 3'd5,
    ST_STAT_OUT = 3'd6,
    ST_STALLED  = 3'd7
  } stage_e;
endpackage

// File: rtl/ctl_setup_decode.sv
module ctl_setup_decode #(
  parameter int LEN_W = 16,
  parameter int MPS   = 64,
  localparam int LOG_MPS = $clog2(MPS),
  localparam int CNT_W = LEN_W - LOG_MPS + 1
) (
  input  logic [63:0]      pkt,
  input  logic [LEN_W-1:0] app_len,
  output logic             dir_in,
  output logic [LEN_W-1:0] req_len,
  output logic [CNT_W-1:0] pkt_cnt
);
  logic [LEN_W-1:0] eff_len;
  logic             part;
  logic             zlp;

  always_comb begin
    dir_in  = pkt[7];
    req_len = pkt[63:48];
    eff_len = (dir_in && (app_len < req_len)) ? app_len : req_len;
    part    = |eff_len[LOG_MPS-1:0];
    zlp     = dir_in && !part && (eff_len < req_len);
    pkt_cnt = CNT_W'(eff_len >> LOG_MPS) + CNT_W'(part) + CNT_W'(zlp);
  end
endmodule

// File: rtl/ctl_resp_map.sv
module ctl_resp_map
  import ctl_ep_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  stage_e           stage,
  input  logic [CNT_W-1:0] remain,
  input  logic             app_done,
  input  logic             had_wr,
  input  logic             tog,
  output rsp_e             in_rsp,
  output rsp_e             out_rsp,
  output logic             data1
);
  always_comb begin
    in_rsp  = RSP_NAK;
    out_rsp = RSP_NAK;
    data1   = tog;
    case (stage)
      ST_DATA_IN: begin
        in_rsp  = RSP_VALID;
        out_rsp = RSP_STALL;
      end
      ST_LAST_IN: begin
        in_rsp  = RSP_VALID;
        out_rsp = RSP_VALID;
      end
      ST_DATA_OUT: begin
        out_rsp = RSP_VALID;
        in_rsp  = (remain == CNT_W'(1)) ? RSP_NAK : RSP_STALL;
      end
      ST_STAT_IN: begin
        in_rsp  = app_done ? RSP_VALID : RSP_NAK;
        out_rsp = had_wr ? RSP_VALID : RSP_STALL;
        data1   = 1'b1;
      end
      ST_STAT_OUT: begin
        in_rsp  = RSP_STALL;
        out_rsp = RSP_VALID;
        data1   = 1'b1;
      end
      ST_STALLED: begin
        in_rsp  = RSP_STALL;
        out_rsp = RSP_STALL;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctl_stage_fsm.sv
module ctl_stage_fsm
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_setup,
  input  logic             tok_in,
  input  logic             tok_out,
  input  logic             setup_vld,
  input  logic             dec_dir_in,
  input  logic [LEN_W-1:0] dec_len,
  input  logic [CNT_W-1:0] dec_cnt,
  input  logic             hs_ack,
  input  logic             odat_ok,
  input  logic             odat_data1,
  input  logic             app_ok,
  input  logic             app_err,
  output stage_e           stage,
  output logic [CNT_W-1:0] remain,
  output logic             tog,
  output logic             app_done,
  output logic             had_wr,
  output logic             done
);
  stage_e           stage_n;
  logic [CNT_W-1:0] remain_n;
  logic             tog_n, app_done_n, had_wr_n, done_n, en;
  logic             active;

  assign en = tok_setup | tok_in | tok_out | setup_vld | hs_ack |
              odat_ok | app_ok | app_err;
  assign active = (stage != ST_IDLE) && (stage != ST_DECODE) &&
                  (stage != ST_STALLED);

  always_comb begin
    stage_n    = stage;
    remain_n   = remain;
    tog_n      = tog;
    app_done_n = app_done | app_ok;
    had_wr_n   = had_wr;
    done_n     = 1'b0;
    if (tok_setup) begin
      stage_n    = ST_DECODE;
      remain_n   = '0;
      tog_n      = 1'b1;
      app_done_n = 1'b0;
      had_wr_n   = 1'b0;
    end else if (app_err && active) begin
      stage_n = ST_STALLED;
    end else begin
      case (stage)
        ST_DECODE: if (setup_vld) begin
          remain_n = dec_cnt;
          tog_n    = 1'b1;
          had_wr_n = !dec_dir_in && (dec_len != '0);
          if (dec_len == '0)            stage_n = ST_STAT_IN;
          else if (!dec_dir_in)         stage_n = ST_DATA_OUT;
          else if (dec_cnt == CNT_W'(1)) stage_n = ST_LAST_IN;
          else                          stage_n = ST_DATA_IN;
        end
        ST_DATA_IN: begin
          if (hs_ack) begin
            tog_n    = !tog;
            remain_n = remain - CNT_W'(1);
            if (remain == CNT_W'(2)) stage_n = ST_LAST_IN;
          end else if (tok_out) begin
            stage_n = ST_STALLED;
          end
        end
        ST_LAST_IN: if (hs_ack || tok_out) begin
          remain_n = '0;
          stage_n  = ST_STAT_OUT;
        end
        ST_DATA_OUT: begin
          if (odat_ok && (odat_data1 == tog)) begin
            tog_n    = !tog;
            remain_n = remain - CNT_W'(1);
            if (remain == CNT_W'(1)) stage_n = ST_STAT_IN;
          end else if (tok_in && (remain != CNT_W'(1))) begin
            stage_n = ST_STALLED;
          end
        end
        ST_STAT_IN: if (hs_ack && app_done) begin
          stage_n = ST_IDLE;
          done_n  = 1'b1;
        end
        ST_STAT_OUT: if (odat_ok) begin
          stage_n = ST_IDLE;
          done_n  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage    <= ST_IDLE;
      remain   <= '0;
      tog      <= 1'b1;
      app_done <= 1'b0;
      had_wr   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= done_n;
      if (en) begin
        stage    <= stage_n;
        remain   <= remain_n;
        tog      <= tog_n;
        app_done <= app_done_n;
        had_wr   <= had_wr_n;
      end
    end
  end
endmodule

// File: rtl/ctl_ep_sequencer.sv
module ctl_ep_sequencer
  import ctl_ep_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS   = 64,
  localparam int CNT_W = LEN_W - $clog2(MPS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_setup,
  input  logic             tok_in,
  input  logic             tok_out,
  input  logic             setup_vld,
  input  logic [63:0]      setup_pkt,
  input  logic [LEN_W-1:0] rd_len,
  input  logic             hs_ack,
  input  logic             odat_ok,
  input  logic             odat_data1,
  input  logic             app_ok,
  input  logic             app_err,
  output logic [1:0]       in_resp,
  output logic [1:0]       out_resp,
  output logic             pid_data1,
  output logic [2:0]       stage,
  output logic             xfer_done
);
  logic [1:0]       rst_sync;
  logic             srst_n;
  logic             dec_dir_in;
  logic [LEN_W-1:0] dec_len;
  logic [CNT_W-1:0] dec_cnt, remain;
  logic             tog, app_done, had_wr;
  stage_e           stage_q;
  rsp_e             in_rsp, out_rsp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  ctl_setup_decode #(.LEN_W(LEN_W), .MPS(MPS)) u_dec (
    .pkt(setup_pkt), .app_len(rd_len), .dir_in(dec_dir_in),
    .req_len(dec_len), .pkt_cnt(dec_cnt)
  );

  ctl_stage_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(srst_n), .tok_setup(tok_setup), .tok_in(tok_in),
    .tok_out(tok_out), .setup_vld(setup_vld), .dec_dir_in(dec_dir_in),
    .dec_len(dec_len), .dec_cnt(dec_cnt), .hs_ack(hs_ack),
    .odat_ok(odat_ok), .odat_data1(odat_data1), .app_ok(app_ok),
    .app_err(app_err), .stage(stage_q), .remain(remain), .tog(tog),
    .app_done(app_done), .had_wr(had_wr), .done(xfer_done)
  );

  ctl_resp_map #(.CNT_W(CNT_W)) u_map (
    .stage(stage_q), .remain(remain), .app_done(app_done), .had_wr(had_wr),
    .tog(tog), .in_rsp(in_rsp), .out_rsp(out_rsp), .data1(pid_data1)
  );

  assign in_resp  = in_rsp;
  assign out_resp = out_rsp;
  assign stage    = stage_q;
endmodule

// File: rtl/ctl_ep_sequencer_chk.sv
module ctl_ep_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_setup,
  input logic       app_err,
  input logic [1:0] in_resp,
  input logic [1:0] out_resp,
  input logic       pid_data1,
  input logic [2:0] stage,
  input logic       xfer_done
);
  AST_SETUP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> (stage == 3'd1 && in_resp == 2'd0 && out_resp == 2'd0)); // R1
  AST_EARLY_OUT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd2) |-> (out_resp == 2'd2 && in_resp == 2'd1)); // R3
  AST_LAST_IN_BOTH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd4) |-> (out_resp == 2'd1 && in_resp == 2'd1)); // R4
  AST_STATUS_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd5 || stage == 3'd6) |-> pid_data1); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd7 && !tok_setup) |=> (stage == 3'd7)); // R11
  AST_STALL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd7) |-> (in_resp == 2'd2 && out_resp == 2'd2)); // R11
endmodule

bind ctl_ep_sequencer ctl_ep_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .app_err(app_err),
  .in_resp(in_resp), .out_resp(out_resp), .pid_data1(pid_data1),
  .stage(stage), .xfer_done(xfer_done)
);

// File: tb/test_ctl_ep_sequencer.sv
module test_ctl_ep_sequencer;
  localparam int MPS = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_setup = 0, tok_in = 0, tok_out = 0, setup_vld = 0;
  logic [63:0] setup_pkt = '0;
  logic [15:0] rd_len = '0;
  logic hs_ack = 0, odat_ok = 0, odat_data1 = 0, app_ok = 0, app_err = 0;
  logic [1:0] in_resp, out_resp;
  logic pid_data1, xfer_done;
  logic [2:0] stage;
  int n_run = 0, n_fail = 0, n_done = 0, exp_done = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ctl_ep_sequencer #(.MPS(MPS)) i_ctl_ep_sequencer (
    .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_in(tok_in),
    .tok_out(tok_out), .setup_vld(setup_vld), .setup_pkt(setup_pkt),
    .rd_len(rd_len), .hs_ack(hs_ack), .odat_ok(odat_ok),
    .odat_data1(odat_data1), .app_ok(app_ok), .app_err(app_err),
    .in_resp(in_resp), .out_resp(out_resp), .pid_data1(pid_data1),
    .stage(stage), .xfer_done(xfer_done)
  );

  always @(negedge clk) if (rst_n && xfer_done) n_done++;

  function automatic int exp_cnt(bit dir, int wlen, int rdl);
    int l = (dir && rdl < wlen) ? rdl : wlen;
    int c = (l + MPS - 1) / MPS;
    if (dir && (l % MPS == 0) && l < wlen) c++;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ev(bit s, bit i, bit o, bit a, bit d, bit t, bit k, bit e);
    tok_setup = s; tok_in = i; tok_out = o; hs_ack = a;
    odat_ok = d; odat_data1 = t; app_ok = k; app_err = e;
    @(negedge clk);
    tok_setup = 0; tok_in = 0; tok_out = 0; hs_ack = 0;
    odat_ok = 0; odat_data1 = 0; app_ok = 0; app_err = 0;
  endtask

  task automatic start(bit dir, int wlen, int rdl);
    ev(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 stage", stage, 1);
    chk("R1 resp", {in_resp, out_resp}, 0);
    setup_pkt = {wlen[15:0], 40'h0, dir, 7'h0};
    rd_len = rdl[15:0];
    setup_vld = 1;
    @(negedge clk);
    setup_vld = 0;
  endtask

  task automatic status_in_close();
    chk("R8 nak before app", in_resp, 0);
    ev(0, 1, 0, 1, 0, 0, 0, 0);
    chk("R8 no close before app", stage, 5);
    ev(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 valid after app", in_resp, 1);
    chk("R9 status data1", pid_data1, 1);
    ev(0, 1, 0, 1, 0, 0, 0, 0);
    exp_done++;
    chk("R10 done", xfer_done, 1);
    chk("R8 idle", stage, 0);
  endtask

  task automatic run_xfer(bit dir, int wlen, int rdl, bit lose);
    int n = exp_cnt(dir, wlen, rdl);
    bit tg = 1;
    start(dir, wlen, rdl);
    if (wlen == 0) begin
      chk("R2 no-data", stage, 5);
      status_in_close();
    end else if (dir) begin
      for (int k = 0; k < n; k++) begin
        chk("R12 R2 in stage", stage, (k == n - 1) ? 4 : 2);
        chk("R3 R4 out resp", out_resp, (k == n - 1) ? 1 : 2);
        chk("R9 in toggle", pid_data1, tg);
        if ($urandom_range(0, 2) == 0) begin
          ev(0, 1, 0, 0, 0, 0, 0, 0);
          chk("R6 retry toggle", pid_data1, tg);
          chk("R6 retry stage", stage, (k == n - 1) ? 4 : 2);
        end
        if (k == n - 1 && lose) begin
          ev(0, 0, 1, 0, 0, 0, 0, 0);
          chk("R5 lost ack closes", stage, 6);
        end else begin
          ev(0, 1, 0, 0, 0, 0, 0, 0);
          ev(0, 0, 0, 1, 0, 0, 0, 0);
        end
        tg = ~tg;
      end
      chk("R4 status out", stage, 6);
      chk("R9 status out data1", pid_data1, 1);
      ev(0, 0, 1, 0, 0, 0, 0, 0);
      ev(0, 0, 0, 0, 1, 1, 0, 0);
      exp_done++;
      chk("R10 R5 done", xfer_done, 1);
      @(negedge clk);
      chk("R10 pulse once", xfer_done, 0);
    end else begin
      for (int k = 0; k < n; k++) begin
        chk("R2 R12 out stage", stage, 3);
        chk("R7 in resp", in_resp, (k == n - 1) ? 0 : 2);
        chk("R9 out toggle", pid_data1, tg);
        if ($urandom_range(0, 2) == 0) begin
          ev(0, 0, 1, 0, 1, ~tg, 0, 0);
          chk("R7 stale ignored", pid_data1, tg);
          chk("R7 stale stage", stage, 3);
        end
        ev(0, 0, 1, 0, 1, tg, 0, 0);
        tg = ~tg;
      end
      chk("R7 to status", stage, 5);
      if (lose) begin
        ev(0, 0, 1, 0, 1, ~tg, 0, 0);
        chk("R7 repeat last", stage, 5);
        chk("R7 repeat accepted", out_resp, 1);
      end
      status_in_close();
    end
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 reset stage", stage, 0);
    chk("R1 reset resp", {in_resp, out_resp}, 0);

    // zero-length-packet rule cases
    run_xfer(1, 256, 128, 0);
    run_xfer(1, 128, 128, 1);
    run_xfer(1, 64, 0, 1);
    run_xfer(1, 100, 300, 0);
    run_xfer(0, 130, 0, 1);
    run_xfer(0, 0, 0, 0);

    // early reversal in a read
    start(1, 200, 200);
    ev(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 early out", stage, 7);
    chk("R11 stall resp", {in_resp, out_resp}, 10);
    ev(0, 1, 0, 1, 0, 0, 0, 0);
    chk("R11 hold", stage, 7);
    // abort stalled via setup, then early reversal in a write
    start(0, 130, 0);
    ev(0, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 early in", stage, 7);
    // setup mid data stage
    start(1, 300, 300);
    ev(0, 1, 0, 1, 0, 0, 0, 0);
    ev(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R1 abort mid data", stage, 1);
    // app failure in status
    setup_pkt = {16'd10, 48'h0}; setup_vld = 1; @(negedge clk); setup_vld = 0;
    ev(0, 0, 1, 0, 1, 1, 0, 0);
    chk("R8 status in", stage, 5);
    ev(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 app err", stage, 7);

    for (int r = 0; r < 40; r++)
      run_xfer($urandom_range(0, 1), $urandom_range(0, 300),
               $urandom_range(0, 300), $urandom_range(0, 1));

    @(negedge clk);
    chk("R10 done count", n_done, exp_done);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule